// File: doc/BRIEF.md
# Sixteen-bit ALU with condition codes

This block is the arithmetic and logic stage of a small word-oriented processor. Each cycle it may accept one operation: a source word, a destination word, a 4-bit operation code, a byte/word select and the present carry flag. One clock later it presents the result, a write-enable for the destination and fresh N (negative), Z (zero), V (overflow) and C (carry) flags for the status register. Operand fetch, addressing and instruction decode sit outside it.

The operations are add, subtract, add-carry, subtract-carry, increment, decrement, clear, bit-clear, bit-set, bit-test, compare, test, one-place arithmetic shifts left and right, rotate right through carry, and byte swap. Compare, bit-test and test only produce flags, so the write-enable stays low for them. In byte mode the operation works on the low byte, and the flags are taken from that byte. The upper byte of the result is the unchanged upper byte of the destination.

Top module: `alu16_ccr`

## Requirements
- R1: Op 0 (add) gives dst+src and op 1 (subtract) gives dst-src. C is the carry out of the add and the borrow of the subtract (1 when dst < src unsigned). V is 1 when the signed result overflows. N is the result sign bit and Z is 1 for a zero result.
- R2: Op 10 (compare) computes src-dst. It shows that value on result with wr_en low. C is 1 when src < dst unsigned, V marks signed overflow, and N is the sign bit of src-dst.
- R3: Op 2 (add-carry) gives dst+c_in and op 3 (subtract-carry) gives dst-c_in. Op 4 (increment) gives dst+1 and op 5 (decrement) gives dst-1. C and V follow the carry/borrow and overflow rules of R1.
- R4: Op 6 (clear) gives result 0 with N=0, Z=1, V=0, C=0 and wr_en high.
- R5: Op 7 (bit-clear) gives dst with every bit cleared where src has a 1. Op 8 (bit-set) gives dst OR src. For both ops and for op 9, V is 0 and the C output equals c_in.
- R6: Op 9 (bit-test) shows dst AND src and op 11 (test) shows dst, both with wr_en low. Test gives V=0 and C=0. N and Z come from the shown value.
- R7: Op 12 (shift left) moves bits up one place, fills bit 0 with 0 and puts the old top bit in C. Op 13 (shift right) keeps the top bit, moves bits down one place and puts the old bit 0 in C. Op 14 (rotate right) puts the old bit 0 in C and c_in in the top bit. For all three, V = N XOR C.
- R8: Op 15 (byte swap) exchanges bits 15:8 and 7:0 of dst over the full word, even when byte_sel is 1. N is bit 15 and Z is set for a zero word, with V=0 and C=0.
- R9: With byte_sel=1, ops 0 to 14 act on bits 7:0 only. Result bits 15:8 equal dst bits 15:8. N is result bit 7, Z tests bits 7:0, and C and V are taken at bit 7.
- R10: An operation sampled with in_valid high at a rising edge appears on the outputs after that edge, with out_valid high for exactly that one cycle. Operations may be issued back to back.
- R11: While rst_n is low, out_valid, result, wr_en and all four flags are 0.
- R12: When in_valid is low at an edge, out_valid goes low and result, wr_en and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| op | input | 4 | Operation code (0 to 15, see requirements) |
| byte_sel | input | 1 | 1 selects byte mode on bits 7:0 |
| c_in | input | 1 | Present C flag |
| out_valid | output | 1 | Outputs hold a new operation's result |
| result | output | 16 | Computed value |
| wr_en | output | 1 | Write result back to the destination |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Two operations can meet at one clock edge. When a writing operation is followed directly by a flag-only one, the first is registered while the second is decoded, and the second must not pick up the first's write-enable or flags. The bench provokes this by issuing an add and then a compare on consecutive cycles, and an increment and then a bit-test. It judges each cycle's outputs against a model, and then checks that an idle cycle leaves the last values in place. Byte mode and byte swap meet in the same decode, so the swap is also run with byte_sel high and must stay full-word.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_ADC  = 4'd2,
      OP_SBC  = 4'd3,
      OP_INC  = 4'd4,
      OP_DEC  = 4'd5,
      OP_CLR  = 4'd6,
      OP_BIC  = 4'd7,
      OP_BIS  = 4'd8,
      OP_BIT  = 4'd9,
      OP_CMP  = 4'd10,
      OP_TST  = 4'd11,
      OP_ASL  = 4'd12,
      OP_ASR  = 4'd13,
      OP_ROR  = 4'd14,
      OP_SWAB = 4'd15
   } alu_op_e;

   // Operations that only report flags and never write the destination
   function automatic logic flag_only(alu_op_e o);
      return (o == OP_BIT) || (o == OP_CMP) || (o == OP_TST);
   endfunction

   function automatic logic is_shift(alu_op_e o);
      return (o == OP_ASL) || (o == OP_ASR) || (o == OP_ROR);
   endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         cy,
   output logic         ovf
);
   localparam int XW = W + 1;

   logic [W-1:0]  b_eff;
   logic [XW-1:0] wide;

   generate
      if (W < 2) begin : g_bad_w
         $error("alu_addsub: W must be at least 2");
      end
   endgenerate

   always_comb begin
      b_eff = sub ? ~b : b;
      wide  = XW'(a) + XW'(b_eff) + XW'(sub);
      sum   = wide[W-1:0];
      // carry for add, borrow for subtract
      cy    = wide[W] ^ sub;
      ovf   = (a[W-1] == b_eff[W-1]) && (wide[W-1] != a[W-1]);
   end
endmodule

// File: rtl/alu_lane.sv
module alu_lane
   import alu16_pkg::*;
#(
   parameter int W = 16
) (
   input  alu_op_e      op,
   input  logic [W-1:0] s,
   input  logic [W-1:0] d,
   input  logic         c_in,
   output logic [W-1:0] r,
   output logic         n,
   output logic         z,
   output logic         v,
   output logic         c
);
   localparam int          HW   = W / 2;
   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] NONE = '0;

   logic [W-1:0] add_a, add_b, add_sum;
   logic         add_sub, add_cy, add_ovf;

   generate
      if (W % 2 != 0) begin : g_bad_w
         $error("alu_lane: W must be even");
      end
   endgenerate

   // adder operand steering
   always_comb begin
      add_a   = d;
      add_b   = s;
      add_sub = 1'b0;
      case (op)
         OP_SUB: add_sub = 1'b1;
         OP_CMP: begin add_a = s; add_b = d; add_sub = 1'b1; end
         OP_ADC: add_b = {{(W-1){1'b0}}, c_in};
         OP_SBC: begin add_b = {{(W-1){1'b0}}, c_in}; add_sub = 1'b1; end
         OP_INC: add_b = ONE;
         OP_DEC: begin add_b = ONE; add_sub = 1'b1; end
         default: ;
      endcase
   end

   alu_addsub #(.W(W)) u_add (
      .a   (add_a),
      .b   (add_b),
      .sub (add_sub),
      .sum (add_sum),
      .cy  (add_cy),
      .ovf (add_ovf)
   );

   always_comb begin
      r = add_sum;
      v = 1'b0;
      c = c_in;
      case (op)
         OP_ADD, OP_SUB, OP_CMP, OP_ADC, OP_SBC, OP_INC, OP_DEC: begin
            r = add_sum;
            v = add_ovf;
            c = add_cy;
         end
         OP_CLR:  begin r = NONE; c = 1'b0; end
         OP_BIC:  r = d & ~s;
         OP_BIS:  r = d | s;
         OP_BIT:  r = d & s;
         OP_TST:  begin r = d; c = 1'b0; end
         OP_ASL:  begin r = {d[W-2:0], 1'b0};  c = d[W-1]; end
         OP_ASR:  begin r = {d[W-1], d[W-1:1]}; c = d[0];   end
         OP_ROR:  begin r = {c_in, d[W-1:1]};   c = d[0];   end
         OP_SWAB: begin r = {d[HW-1:0], d[W-1:HW]}; c = 1'b0; end
         default: ;
      endcase
      n = r[W-1];
      z = ~|r;
      if (is_shift(op)) v = n ^ c;
   end
endmodule

// File: rtl/alu16_ccr.sv
module alu16_ccr
   import alu16_pkg::*;
#(
   parameter int WIDTH        = 16,
   parameter bit BYTE_MODE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] src,
   input  logic [WIDTH-1:0] dst,
   input  logic [3:0]       op,
   input  logic             byte_sel,
   input  logic             c_in,
   output logic             out_valid,
   output logic [WIDTH-1:0] result,
   output logic             wr_en,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_v,
   output logic             flag_c
);
   localparam int BW = WIDTH / 2;

   generate
      if (WIDTH < 4 || WIDTH % 4 != 0) begin : g_bad_width
         $error("alu16_ccr: WIDTH must be a multiple of 4");
      end
   endgenerate

   alu_op_e          op_e;
   logic [WIDTH-1:0] w_r, nxt_r;
   logic             w_n, w_z, w_v, w_c;
   logic             nxt_n, nxt_z, nxt_v, nxt_c, nxt_we;
   alu_op_e          op_q;
   logic             byte_q;

   assign op_e   = alu_op_e'(op);
   assign nxt_we = ~flag_only(op_e);

   alu_lane #(.W(WIDTH)) u_word (
      .op   (op_e),
      .s    (src),
      .d    (dst),
      .c_in (c_in),
      .r    (w_r),
      .n    (w_n),
      .z    (w_z),
      .v    (w_v),
      .c    (w_c)
   );

   generate
      if (BYTE_MODE_EN) begin : g_byte
         logic [BW-1:0] b_r;
         logic          b_n, b_z, b_v, b_c;
         logic          use_byte;

         alu_lane #(.W(BW)) u_byte (
            .op   (op_e),
            .s    (src[BW-1:0]),
            .d    (dst[BW-1:0]),
            .c_in (c_in),
            .r    (b_r),
            .n    (b_n),
            .z    (b_z),
            .v    (b_v),
            .c    (b_c)
         );

         // byte swap always spans the full word
         assign use_byte = byte_sel && (op_e != OP_SWAB);
         assign nxt_r    = use_byte ? {dst[WIDTH-1:BW], b_r} : w_r;
         assign nxt_n    = use_byte ? b_n : w_n;
         assign nxt_z    = use_byte ? b_z : w_z;
         assign nxt_v    = use_byte ? b_v : w_v;
         assign nxt_c    = use_byte ? b_c : w_c;
      end else begin : g_word_only
         assign nxt_r = w_r;
         assign nxt_n = w_n;
         assign nxt_z = w_z;
         assign nxt_v = w_v;
         assign nxt_c = w_c;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         wr_en     <= 1'b0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         flag_v    <= 1'b0;
         flag_c    <= 1'b0;
         op_q      <= OP_ADD;
         byte_q    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= nxt_r;
            wr_en  <= nxt_we;
            flag_n <= nxt_n;
            flag_z <= nxt_z;
            flag_v <= nxt_v;
            flag_c <= nxt_c;
            op_q   <= op_e;
            byte_q <= byte_sel;
         end
      end
   end

   // ---------------- assertions ----------------
   AST_FLAG_ONLY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && flag_only(op_e) |=> out_valid && !wr_en); // R6

   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_e == OP_CMP |=> !wr_en); // R2

   AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_e == OP_CLR |=> flag_z && !flag_n && !flag_v && !flag_c && wr_en); // R4

   AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (op_e == OP_BIC || op_e == OP_BIS || op_e == OP_BIT)
      |=> flag_c == $past(c_in) && !flag_v); // R5

   AST_SHIFT_V: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && is_shift(op_q) |-> flag_v == (flag_n ^ flag_c)); // R7

   AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && BYTE_MODE_EN && byte_sel && op_e != OP_SWAB
      |=> result[WIDTH-1:BW] == $past(dst[WIDTH-1:BW])); // R9

   AST_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && byte_q && op_q != OP_SWAB |-> flag_z == (result[BW-1:0] == '0)); // R9

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R10

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(result) && $stable(wr_en)); // R12
endmodule

// File: tb/sim_alu16_ccr.sv
`timescale 1ns/1ps
module sim_alu16_ccr;
   import alu16_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] src = '0, dst = '0;
   logic [3:0]  op = '0;
   logic        byte_sel = 1'b0, c_in = 1'b0;
   logic        out_valid, wr_en, flag_n, flag_z, flag_v, flag_c;
   logic [15:0] result;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   always #2 clk = ~clk;   // 250 MHz

   alu16_ccr u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .dst(dst),
      .op(op), .byte_sel(byte_sel), .c_in(c_in), .out_valid(out_valid),
      .result(result), .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z),
      .flag_v(flag_v), .flag_c(flag_c)
   );

   localparam logic [15:0] CORNER [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};

   function automatic int sval(int val, int msb);
      return (val >= msb) ? val - 2 * msb : val;
   endfunction

   // Independent model built from the requirements
   task automatic model(input int o, input logic [15:0] s, input logic [15:0] d,
                        input logic b, input logic c,
                        output logic [15:0] er, output logic ew,
                        output logic en, output logic ez, output logic ev, output logic ec);
      int m, msb, a, x, r, ci;
      logic bb;
      bb  = b && (o != 15);
      m   = bb ? 255 : 65535;
      msb = bb ? 128 : 32768;
      a   = int'(d) & m;
      x   = int'(s) & m;
      ci  = c ? 1 : 0;
      ew  = 1'b1;
      ev  = 1'b0;
      ec  = c;
      r   = 0;
      case (o)
         0:  begin r = (a + x) & m;  ec = (a + x) > m; ev = (sval(a,msb) + sval(x,msb)) != sval(r,msb); end
         1:  begin r = (a - x) & m;  ec = a < x;       ev = (sval(a,msb) - sval(x,msb)) != sval(r,msb); end
         2:  begin r = (a + ci) & m; ec = (a + ci) > m; ev = (sval(a,msb) + ci) != sval(r,msb); end
         3:  begin r = (a - ci) & m; ec = a < ci;      ev = (sval(a,msb) - ci) != sval(r,msb); end
         4:  begin r = (a + 1) & m;  ec = (a + 1) > m; ev = (sval(a,msb) + 1) != sval(r,msb); end
         5:  begin r = (a - 1) & m;  ec = a < 1;       ev = (sval(a,msb) - 1) != sval(r,msb); end
         6:  begin r = 0; ec = 1'b0; end
         7:  r = a & ~x & m;
         8:  r = a | x;
         9:  begin r = a & x; ew = 1'b0; end
         10: begin r = (x - a) & m; ec = x < a; ev = (sval(x,msb) - sval(a,msb)) != sval(r,msb); ew = 1'b0; end
         11: begin r = a; ec = 1'b0; ew = 1'b0; end
         12: begin r = (a << 1) & m; ec = (a & msb) != 0; end
         13: begin r = (a >> 1) | (a & msb); ec = (a & 1) != 0; end
         14: begin r = (a >> 1) | (c ? msb : 0); ec = (a & 1) != 0; end
         default: begin r = (a >> 8) | ((a & 255) << 8); ec = 1'b0; end
      endcase
      en = (r & msb) != 0;
      ez = (r == 0);
      if (o >= 12 && o <= 14) ev = en ^ ec;
      er = bb ? {d[15:8], r[7:0]} : r[15:0];
   endtask

   function automatic string tag_of(int o);
      case (o)
         0, 1:         return "R1";
         10:           return "R2";
         2, 3, 4, 5:   return "R3";
         6:            return "R4";
         7, 8:         return "R5";
         9, 11:        return "R6";
         12, 13, 14:   return "R7";
         default:      return "R8";
      endcase
   endfunction

   task automatic compare_out(input string tag, input logic [15:0] er, input logic ew,
                              input logic en, input logic ez, input logic ev, input logic ec,
                              input logic evld);
      checks++;
      if (result !== er || wr_en !== ew || {flag_n, flag_z, flag_v, flag_c} !== {en, ez, ev, ec}
          || out_valid !== evld) begin
         errors++;
         $display("FAIL %s: got vld=%b res=%h we=%b nzvc=%b%b%b%b, expected vld=%b res=%h we=%b nzvc=%b%b%b%b",
                  tag, out_valid, result, wr_en, flag_n, flag_z, flag_v, flag_c,
                  evld, er, ew, en, ez, ev, ec);
      end
   endtask

   task automatic drive(input int o, input logic [15:0] s, input logic [15:0] d,
                        input logic b, input logic c);
      op = 4'(o); src = s; dst = d; byte_sel = b; c_in = c; in_valid = 1'b1;
   endtask

   // issue one operation at a falling edge, check it at the next falling edge
   task automatic run_one(input string tag, input int o, input logic [15:0] s,
                          input logic [15:0] d, input logic b, input logic c);
      logic [15:0] er; logic ew, en, ez, ev, ec;
      model(o, s, d, b, c, er, ew, en, ez, ev, ec);
      @(negedge clk);
      drive(o, s, d, b, c);
      @(negedge clk);
      in_valid = 1'b0;
      compare_out(tag, er, ew, en, ez, ev, ec, 1'b1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      compare_out("R11 reset state", 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_arith();
      foreach (CORNER[i]) foreach (CORNER[j]) begin
         run_one("R1 add", 0, CORNER[i], CORNER[j], 1'b0, 1'b0);
         run_one("R1 sub", 1, CORNER[i], CORNER[j], 1'b0, 1'b1);
      end
      run_one("R1 add small", 0, 16'h0003, 16'h0004, 1'b0, 1'b0);
   endtask

   task automatic t_compare();
      foreach (CORNER[i]) foreach (CORNER[j])
         run_one("R2 cmp", 10, CORNER[i], CORNER[j], 1'b0, 1'b0);
      run_one("R2 cmp src<dst", 10, 16'h0001, 16'h0002, 1'b0, 1'b0);
      run_one("R2 cmp equal", 10, 16'h1234, 16'h1234, 1'b0, 1'b1);
   endtask

   task automatic t_carry_ops();
      foreach (CORNER[i]) begin
         for (int c = 0; c < 2; c++) begin
            run_one("R3 adc", 2, 16'h5555, CORNER[i], 1'b0, c[0]);
            run_one("R3 sbc", 3, 16'h5555, CORNER[i], 1'b0, c[0]);
         end
         run_one("R3 inc", 4, 16'h0, CORNER[i], 1'b0, 1'b0);
         run_one("R3 dec", 5, 16'h0, CORNER[i], 1'b0, 1'b1);
      end
   endtask

   task automatic t_clear();
      run_one("R4 clr", 6, 16'hFFFF, 16'hA5A5, 1'b0, 1'b1);
      run_one("R4 clr byte", 6, 16'h0, 16'hA5A5, 1'b1, 1'b1);
   endtask

   task automatic t_logic();
      for (int c = 0; c < 2; c++) begin
         run_one("R5 bic", 7, 16'h0FF0, 16'hFFFF, 1'b0, c[0]);
         run_one("R5 bic all", 7, 16'hFFFF, 16'h8001, 1'b0, c[0]);
         run_one("R5 bis", 8, 16'h8000, 16'h0001, 1'b0, c[0]);
         run_one("R5 bis zero", 8, 16'h0000, 16'h0000, 1'b0, c[0]);
      end
   endtask

   task automatic t_flag_only();
      for (int c = 0; c < 2; c++) begin
         run_one("R6 bit", 9, 16'hF0F0, 16'h8F0F, 1'b0, c[0]);
         run_one("R6 bit zero", 9, 16'h00FF, 16'hFF00, 1'b0, c[0]);
         foreach (CORNER[i]) run_one("R6 tst", 11, 16'h1111, CORNER[i], 1'b0, c[0]);
      end
   endtask

   task automatic t_shift();
      foreach (CORNER[i]) for (int c = 0; c < 2; c++) begin
         run_one("R7 asl", 12, 16'h0, CORNER[i], 1'b0, c[0]);
         run_one("R7 asr", 13, 16'h0, CORNER[i], 1'b0, c[0]);
         run_one("R7 ror", 14, 16'h0, CORNER[i], 1'b0, c[0]);
      end
      run_one("R7 asl 4000", 12, 16'h0, 16'h4000, 1'b0, 1'b0);
      run_one("R7 ror 0001", 14, 16'h0, 16'h0001, 1'b0, 1'b0);
   endtask

   task automatic t_swab();
      run_one("R8 swab", 15, 16'h0, 16'h12F4, 1'b0, 1'b1);
      run_one("R8 swab byte_sel", 15, 16'h0, 16'h80FF, 1'b1, 1'b1);
      run_one("R8 swab zero", 15, 16'h0, 16'h0000, 1'b0, 1'b0);
   endtask

   task automatic t_byte();
      for (int o = 0; o < 15; o++) begin
         run_one("R9 byte corner", o, 16'hAB7F, 16'hCD80, 1'b1, 1'b1);
         run_one("R9 byte corner2", o, 16'h12FF, 16'h34FF, 1'b1, 1'b0);
         for (int k = 0; k < 3; k++)
            run_one("R9 byte random", o, 16'($urandom), 16'($urandom), 1'b1, 1'($urandom));
      end
   endtask

   // a writer and a flag-only op meet at one edge, then an idle cycle
   task automatic t_timing();
      logic [15:0] ar, br; logic aw, an, az, av, ac, bw, bn, bz, bv, bc;
      model(0, 16'h7FFF, 16'h0001, 1'b0, 1'b0, ar, aw, an, az, av, ac);
      model(10, 16'h0005, 16'h0009, 1'b0, 1'b1, br, bw, bn, bz, bv, bc);
      @(negedge clk);
      drive(0, 16'h7FFF, 16'h0001, 1'b0, 1'b0);
      @(negedge clk);
      compare_out("R10 first of pair", ar, aw, an, az, av, ac, 1'b1);
      drive(10, 16'h0005, 16'h0009, 1'b0, 1'b1);
      @(negedge clk);
      compare_out("R10 second of pair", br, bw, bn, bz, bv, bc, 1'b1);
      in_valid = 1'b0;
      op = 4'd6;
      @(negedge clk);
      compare_out("R12 idle holds", br, bw, bn, bz, bv, bc, 1'b0);
      @(negedge clk);
      compare_out("R12 idle holds again", br, bw, bn, bz, bv, bc, 1'b0);

      model(4, 16'h0, 16'hFFFF, 1'b0, 1'b0, ar, aw, an, az, av, ac);
      model(9, 16'h8000, 16'h8001, 1'b0, 1'b0, br, bw, bn, bz, bv, bc);
      drive(4, 16'h0, 16'hFFFF, 1'b0, 1'b0);
      @(negedge clk);
      compare_out("R10 inc then bit", ar, aw, an, az, av, ac, 1'b1);
      drive(9, 16'h8000, 16'h8001, 1'b0, 1'b0);
      @(negedge clk);
      compare_out("R10 bit after inc", br, bw, bn, bz, bv, bc, 1'b1);
      in_valid = 1'b0;
   endtask

   task automatic t_random();
      for (int k = 0; k < 160; k++) begin
         int o;
         o = k % 16;
         run_one(tag_of(o), o, 16'($urandom), 16'($urandom), 1'b0, 1'($urandom));
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_arith();
      t_compare();
      t_carry_ops();
      t_clear();
      t_logic();
      t_flag_only();
      t_shift();
      t_swab();
      t_byte();
      t_timing();
      t_random();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      #(200000 * 4);
      errors++;
      checks++;
      $display("FAIL watchdog: got no completion, expected finish before timeout");
      finish_run();
   end
endmodule